// File: doc/BRIEF.md
# Half to single float widener

This block turns one IEEE-754 binary16 word into the binary32 word that holds exactly the same number. A result is always exact, so no rounding is done. Every class of input is handled: signed zeros, subnormals, normal numbers, infinities and NaNs. A half-precision subnormal has no implicit leading one. Single precision has enough exponent range to show it as a normal number, so the block finds the leading one in the fraction, shifts it into the hidden-bit place and lowers the exponent to match.

The converter has one register stage. The caller presents a word with `in_valid` high, and the widened word appears on `out_single` one clock later with `out_valid` high. The input is split into a class (zero, subnormal, normal, special), and a `unique case` on that class selects how the output fields are assembled. A priority encoder and a logarithmic barrel shifter do the subnormal normalization in a single pass, without iterating.

Top module: `h2s_widen`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock edge. A synchronous active-high `rst` clears `out_valid` and `out_single` to zero.
- R2: Output bit 31 equals input bit 15 for every input code.
- R3: An input whose bits 14:0 are all zero gives an output whose bits 30:0 are all zero, so the sign is kept.
- R4: For an input exponent field (bits 14:10) from 1 to 30, the output exponent (bits 30:23) is that field plus 112. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are zero.
- R5: For an input exponent field of 0 and a nonzero fraction whose highest set bit is at position p (0..9), the output exponent is 103+p. The fraction bits below p, moved up so that bit p-1 lands at output bit 22, fill the output fraction, and all other fraction bits are zero.
- R6: Input exponent 31 with fraction 0 gives output exponent 255 with fraction 0.
- R7: Input exponent 31 with a nonzero fraction gives output exponent 255, output bits 22:13 equal to input bits 9:0, and output bits 12:0 all set to one.
- R8: While `in_valid` is low, `out_single` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_half` as a word to convert |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | Marks `out_single` as holding a new result |
| out_single | output | 32 | binary32 result |

## Verification
Every result, data and valid alike, is due on the first rising edge after the edge that captured the input, so each result is exactly one clock behind its stimulus. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a period after the capturing edge. A check therefore always sees the result of the word driven one cycle earlier. The hold and reset checks use the same one-cycle window: they change `in_half` with `in_valid` low, or assert `rst`, and read the outputs at the following falling edge.

// File: rtl/h2s_pkg.sv
`timescale 1ns/1ps
package h2s_pkg;
    localparam int HALF_EXP_W  = 5;
    localparam int HALF_FRAC_W = 10;
    localparam int HALF_W      = 1 + HALF_EXP_W + HALF_FRAC_W;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int SGL_W       = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int HALF_BIAS   = (1 << (HALF_EXP_W - 1)) - 1;
    localparam int SGL_BIAS    = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int REBIAS      = SGL_BIAS - HALF_BIAS;
    localparam int PAD_W       = SGL_FRAC_W - HALF_FRAC_W;
    localparam int LZ_W        = $clog2(HALF_FRAC_W);

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_SPECIAL
    } in_class_e;
endpackage

// File: rtl/h2s_split.sv
`timescale 1ns/1ps
module h2s_split
    import h2s_pkg::*;
(
    input  logic [HALF_W-1:0]      word,
    output logic                   sign,
    output logic [HALF_EXP_W-1:0]  expo,
    output logic [HALF_FRAC_W-1:0] frac,
    output in_class_e              cls
);
    logic exp_zero;
    logic exp_full;

    assign sign     = word[HALF_W-1];
    assign expo     = word[HALF_W-2:HALF_FRAC_W];
    assign frac     = word[HALF_FRAC_W-1:0];
    assign exp_zero = (expo == '0);
    assign exp_full = (expo == '1);

    always_comb begin
        if (exp_full)
            cls = CLS_SPECIAL;
        else if (!exp_zero)
            cls = CLS_NORM;
        else if (frac != '0)
            cls = CLS_SUB;
        else
            cls = CLS_ZERO;
    end
endmodule

// File: rtl/h2s_lead_one.sv
`timescale 1ns/1ps
module h2s_lead_one #(
    parameter int W  = 10,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] lz
);
    logic [W-1:0] clear_above;
    logic [W-1:0] hit;

    genvar i;
    generate
        for (i = W - 1; i >= 0; i--) begin : g_chain
            if (i == W - 1) begin : g_top
                assign clear_above[i] = 1'b1;
            end else begin : g_rest
                assign clear_above[i] = clear_above[i+1] & ~vec[i+1];
            end
            assign hit[i] = vec[i] & clear_above[i];
        end
    endgenerate

    always_comb begin
        lz = '0;
        for (int k = 0; k < W; k++) begin
            if (hit[k])
                lz = lz | CW'(W - 1 - k);
        end
    end
endmodule

// File: rtl/h2s_lshift.sv
`timescale 1ns/1ps
module h2s_lshift #(
    parameter int W  = 10,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [SW+1];

    assign stg[0] = din;

    genvar s;
    generate
        for (s = 0; s < SW; s++) begin : g_stage
            assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
        end
    endgenerate

    assign dout = stg[SW];
endmodule

// File: rtl/h2s_widen.sv
`timescale 1ns/1ps
module h2s_widen
    import h2s_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    output logic              out_valid,
    output logic [SGL_W-1:0]  out_single
);
    logic                   sign;
    logic [HALF_EXP_W-1:0]  expo;
    logic [HALF_FRAC_W-1:0] frac;
    in_class_e              cls;
    logic [LZ_W-1:0]        lz;
    logic [HALF_FRAC_W-1:0] norm;
    logic [SGL_W-1:0]       wide;

    h2s_split u_split (
        .word (in_half),
        .sign (sign),
        .expo (expo),
        .frac (frac),
        .cls  (cls)
    );

    h2s_lead_one #(.W(HALF_FRAC_W), .CW(LZ_W)) u_lead (
        .vec (frac),
        .lz  (lz)
    );

    h2s_lshift #(.W(HALF_FRAC_W), .SW(LZ_W)) u_shift (
        .din  (frac),
        .amt  (lz),
        .dout (norm)
    );

    always_comb begin
        unique case (cls)
            CLS_ZERO:
                wide = {sign, {(SGL_W-1){1'b0}}};
            CLS_SUB:
                wide = {sign,
                        SGL_EXP_W'(REBIAS) - SGL_EXP_W'(lz),
                        norm[HALF_FRAC_W-2:0], 1'b0,
                        {PAD_W{1'b0}}};
            CLS_NORM:
                wide = {sign,
                        SGL_EXP_W'(expo) + SGL_EXP_W'(REBIAS),
                        frac,
                        {PAD_W{1'b0}}};
            CLS_SPECIAL:
                wide = {sign, {SGL_EXP_W{1'b1}}, frac, {PAD_W{frac != '0}}};
            default:
                wide = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_single <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_single <= wide;
        end
    end
endmodule

// File: rtl/h2s_widen_chk.sv
`timescale 1ns/1ps
module h2s_widen_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] in_half,
    input logic        out_valid,
    input logic [31:0] out_single
);
    logic rst_seen = 1'b0;
    logic armed    = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst_seen | rst;
        armed    <= rst_seen & ~rst;
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid)));

    // R2
    sign_move_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |-> (out_single[31] == $past(in_half[15])));

    // R3
    signed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_half[14:0]) == 15'd0)
            |-> (out_single[30:0] == 31'd0));

    // R4
    normal_field_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_half[14:10]) != 5'd0
               && $past(in_half[14:10]) != 5'd31)
            |-> (out_single[30:23] == {3'd0, $past(in_half[14:10])} + 8'd112
                 && out_single[22:13] == $past(in_half[9:0])
                 && out_single[12:0] == 13'd0));

    // R5
    subnormal_range_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_half[14:10]) == 5'd0
               && $past(in_half[9:0]) != 10'd0)
            |-> (out_single[30:23] >= 8'd103 && out_single[30:23] <= 8'd112
                 && out_single[12:0] == 13'd0));

    // R6
    infinity_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_half[14:10]) == 5'd31
               && $past(in_half[9:0]) == 10'd0)
            |-> (out_single[30:0] == 31'h7F80_0000));

    // R7
    nan_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid && $past(in_half[14:10]) == 5'd31
               && $past(in_half[9:0]) != 10'd0)
            |-> (out_single[30:23] == 8'hFF
                 && out_single[22:13] == $past(in_half[9:0])
                 && out_single[12:0] == 13'h1FFF));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(in_valid)) |-> $stable(out_single));
endmodule

bind h2s_widen h2s_widen_chk u_chk (.*);

// File: tb/h2s_widen_bench.sv
`timescale 1ns/1ps
module h2s_widen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = 16'h0;
    logic        out_valid;
    logic [31:0] out_single;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    h2s_widen u_h2s_widen (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .out_valid  (out_valid),
        .out_single (out_single)
    );

    localparam int NVEC = 15;
    localparam logic [47:0] VEC [NVEC] = '{
        {16'h0000, 32'h0000_0000},
        {16'h8000, 32'h8000_0000},
        {16'h3C00, 32'h3F80_0000},
        {16'hC000, 32'hC000_0000},
        {16'h7BFF, 32'h477F_E000},
        {16'h0400, 32'h3880_0000},
        {16'h3555, 32'h3EAA_A000},
        {16'h0001, 32'h3380_0000},
        {16'h0003, 32'h3440_0000},
        {16'h03FF, 32'h387F_C000},
        {16'h8200, 32'hB800_0000},
        {16'h7C00, 32'h7F80_0000},
        {16'hFC00, 32'hFF80_0000},
        {16'h7E00, 32'h7FC0_1FFF},
        {16'h7C01, 32'h7F80_3FFF}
    };

    function automatic string tag_of(logic [15:0] h);
        if (h[14:10] == 5'd31) return (h[9:0] != 0) ? "R7" : "R6";
        if (h[14:10] == 5'd0)  return (h[9:0] != 0) ? "R5" : "R3";
        return "R4";
    endfunction

    function automatic logic [31:0] ref_widen(logic [15:0] h);
        logic [31:0] m;
        int          e;
        m = 32'(h[9:0]) << 13;
        if (h[14:10] == 5'd0) begin
            if (h[9:0] == 10'd0) return {h[15], 31'd0};
            e = 113;
            while ((m & 32'h0080_0000) == 0) begin
                m = m << 1;
                e = e - 1;
            end
            m = m & 32'h007F_FFFF;
            return {h[15], 8'(e), m[22:0]};
        end
        if (h[14:10] == 5'd31) begin
            if (h[9:0] != 10'd0) m = m | 32'h1FFF;
            return {h[15], 8'hFF, m[22:0]};
        end
        e = int'(h[14:10]) + 112;
        return {h[15], 8'(e), m[22:0]};
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] h);
        in_half  = h;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check32("R1", {31'd0, out_valid}, 32'd0);
        check32("R1", out_single, 32'd0);
        rst = 1'b0;

        // table of directed vectors
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][47:32]);
            check32(tag_of(VEC[i][47:32]), out_single, VEC[i][31:0]);
            check32("R1", {31'd0, out_valid}, 32'd1);
        end

        // exhaustive sweep against the behavioural model
        for (int c = 0; c < 65536; c++) begin
            apply(16'(c));
            check32(tag_of(16'(c)), out_single, ref_widen(16'(c)));
            check32("R2", {31'd0, out_single[31]}, {31'd0, in_half[15]});
        end
        last = ref_widen(16'hFFFF);

        // R8: idle input changes leave the result alone
        in_valid = 1'b0;
        in_half  = 16'h3C00;
        @(posedge clk);
        @(negedge clk);
        check32("R1", {31'd0, out_valid}, 32'd0);
        check32("R8", out_single, last);
        in_half = 16'h0001;
        @(posedge clk);
        @(negedge clk);
        check32("R8", out_single, last);

        // R1: reset in the middle of traffic
        apply(16'h4000);
        check32("R4", out_single, 32'h4000_0000);
        rst = 1'b1;
        in_half = 16'h3C00;
        @(posedge clk);
        @(negedge clk);
        check32("R1", {31'd0, out_valid}, 32'd0);
        check32("R1", out_single, 32'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check32("R1", {31'd0, out_valid}, 32'd0);
        apply(16'h8001);
        check32("R5", out_single, 32'hB380_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule